// File: doc/BRIEF.md
# Three-Wire Serial Register Target

This block is the target side of a slow three-wire control bus. The bus has an active-low select, a bus clock driven by the master, and one shared data line. The block turns serial frames into accesses on a simple parallel register port. A frame opens with a 9-bit header that carries the target number, the direction and the register index. A 16-bit data phase follows. On a write the data phase is received and then handed to the register port. On a read the register is fetched as soon as the header ends, and its value is shifted back out on the data line.

All three bus inputs are resynchronised to the system clock through a two-flop chain. Bus clock rising edges are then found by comparing successive synchronised samples, so the bus clock is treated as data rather than as a clock. After each data phase the block drops straight back to header reception. A master can therefore chain frames while keeping select low. A target whose configured number does not match the header stays quiet for the whole data phase.

Top module: `sbt_target`

## Requirements
- R1: Bits are taken from the data line, and output bits advance, only on a rising bus clock edge seen while select is low. Clock activity while select is high changes nothing and produces no strobe.
- R2: Select going high abandons any frame in progress. Afterwards the block expects a fresh header, its shift state is cleared and the output enable is low. A partially sent frame produces no write strobe.
- R3: The header is 9 bits, sent most significant bit first. Bits 8:6 hold the target number, bit 5 is 1 for a read and 0 for a write, and bits 4:0 hold the register index, which is presented on `reg_idx`.
- R4: On a matching write, 16 data bits are received MSB first. Exactly one `reg_wr` pulse, one system clock wide, carries `reg_idx` and `reg_wdata`. It comes after the 16th bit and never after only 15.
- R5: On a matching read, one `reg_rd` pulse is issued right after the 9th header bit, and `reg_rdata` must be valid while it is high. The captured value is then driven MSB first: bit 15 appears after the first data-phase rising edge, and the next bit after each following edge.
- R6: After the 16th data bit the block returns to header reception with select still low, and the next header is decoded normally.
- R7: A header whose target number differs from the `TARGET_ID` parameter produces no strobe and never raises the output enable. `reg_sel` stays low.
- R8: `bus_dat_oe` rises when the header of a matching read completes. It stays high through the 16 data edges and falls at the next rising edge or when select goes high. It is never high for a write.
- R9: After reset, `bus_dat_oe`, `bus_dat_out`, `reg_sel`, `reg_rd` and `reg_wr` are all low.
- R10: `reg_sel` goes high when a matching header completes. It stays high until the next header completes or select goes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel_n | input | 1 | Bus select, active low |
| bus_clk | input | 1 | Bus clock from the master |
| bus_dat_in | input | 1 | Data line as seen at the pad input |
| bus_dat_out | output | 1 | Data value to drive during reads |
| bus_dat_oe | output | 1 | Pad output enable for the data line |
| reg_sel | output | 1 | Current frame is addressed to this target |
| reg_rd | output | 1 | Read strobe, one system clock wide |
| reg_wr | output | 1 | Write strobe, one system clock wide |
| reg_idx | output | 5 | Register index from the header |
| reg_wdata | output | 16 | Write data, valid with `reg_wr` |
| reg_rdata | input | 16 | Read data, sampled while `reg_rd` is high |

## Verification
The hardest condition to reach is a frame cut short by select. This matters most in the data phase of a read: the read strobe has already fired and the output enable is high. The stimulus raises select after a few data edges of a read, and also after a few header bits. It then checks that the enable has dropped and that a complete frame sent afterwards decodes cleanly. Back-to-back frames with select held low come from walking the whole vector table without releasing select. That run mixes matching and non-matching targets, so a stale match or stale direction would show up on the very next frame.

// File: rtl/sbt_pkg.sv
package sbt_pkg;
  localparam int unsigned DEV_W  = 3;
  localparam int unsigned REG_W  = 5;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned HDR_W  = DEV_W + 1 + REG_W;

  typedef enum logic {PH_HDR = 1'b0, PH_DATA = 1'b1} phase_e;

  typedef struct packed {
    logic [DEV_W-1:0] dev;
    logic             rd;
    logic [REG_W-1:0] idx;
  } hdr_t;

  // Split a completed header word into its fields (target, direction, index).
  function automatic hdr_t hdr_split(input logic [HDR_W-1:0] v);
    hdr_t h;
    h.dev = v[HDR_W-1 -: DEV_W];
    h.rd  = v[REG_W];
    h.idx = v[REG_W-1:0];
    return h;
  endfunction

  // MSB-first shift: the new bit enters at the bottom.
  function automatic logic [DATA_W-1:0] shift_in(input logic [DATA_W-1:0] v, input logic b);
    return {v[DATA_W-2:0], b};
  endfunction
endpackage

// File: rtl/sbt_sync.sv
module sbt_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_n_raw,
  input  logic bclk_raw,
  input  logic dat_raw,
  output logic sel_n_s,
  output logic dat_s,
  output logic bclk_rise
);
  logic [STAGES-1:0] sel_sh, clk_sh, dat_sh;
  logic              clk_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_sh   <= '1;
      clk_sh   <= '0;
      dat_sh   <= '0;
      clk_prev <= 1'b0;
    end else begin
      sel_sh   <= {sel_sh[STAGES-2:0], sel_n_raw};
      clk_sh   <= {clk_sh[STAGES-2:0], bclk_raw};
      dat_sh   <= {dat_sh[STAGES-2:0], dat_raw};
      clk_prev <= clk_sh[STAGES-1];
    end
  end

  assign sel_n_s   = sel_sh[STAGES-1];
  assign dat_s     = dat_sh[STAGES-1];
  assign bclk_rise = clk_sh[STAGES-1] & ~clk_prev;
endmodule

// File: rtl/sbt_frame.sv
module sbt_frame
  import sbt_pkg::*;
#(
  parameter logic [DEV_W-1:0] TARGET_ID = 3'd1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n_s,
  input  logic              dat_s,
  input  logic              bclk_rise,
  input  logic [DATA_W-1:0] rdata,
  output logic              hit,
  output logic              rd_stb,
  output logic              wr_stb,
  output logic [REG_W-1:0]  idx,
  output logic [DATA_W-1:0] wdata,
  output logic              dat_out,
  output logic              dat_oe
);
  localparam int unsigned MAXB  = (DATA_W > HDR_W) ? DATA_W : HDR_W;
  localparam int unsigned CNT_W = $clog2(MAXB);
  localparam logic [CNT_W-1:0] HDR_TOP  = CNT_W'(HDR_W - 1);
  localparam logic [CNT_W-1:0] DATA_TOP = CNT_W'(DATA_W - 1);

  phase_e            phase;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] shreg, rd_buf;
  logic              rd_flag;

  // Named internal events
  logic              bit_evt, last_bit, hdr_done, data_done, match_c;
  logic [DATA_W-1:0] shift_next;
  hdr_t              hdr_c;

  assign bit_evt    = bclk_rise & ~sel_n_s;
  assign last_bit   = (cnt == '0);
  assign shift_next = shift_in(shreg, dat_s);
  assign hdr_c      = hdr_split(shift_next[HDR_W-1:0]);
  assign match_c    = (hdr_c.dev == TARGET_ID);
  assign hdr_done   = bit_evt & (phase == PH_HDR)  & last_bit;
  assign data_done  = bit_evt & (phase == PH_DATA) & last_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_HDR;
      cnt     <= HDR_TOP;
      shreg   <= '0;
      rd_buf  <= '0;
      rd_flag <= 1'b0;
      hit     <= 1'b0;
      idx     <= '0;
      wdata   <= '0;
      dat_out <= 1'b0;
      dat_oe  <= 1'b0;
      rd_stb  <= 1'b0;
      wr_stb  <= 1'b0;
    end else begin
      rd_stb <= 1'b0;
      wr_stb <= 1'b0;
      if (rd_stb) rd_buf <= rdata;
      if (sel_n_s) begin
        phase   <= PH_HDR;
        cnt     <= HDR_TOP;
        shreg   <= '0;
        hit     <= 1'b0;
        dat_oe  <= 1'b0;
        dat_out <= 1'b0;
      end else if (bit_evt) begin
        if (phase == PH_HDR) begin
          dat_oe  <= 1'b0;
          dat_out <= 1'b0;
          if (hdr_done) begin
            hit     <= match_c;
            rd_flag <= hdr_c.rd;
            idx     <= hdr_c.idx;
            rd_stb  <= match_c & hdr_c.rd;
            dat_oe  <= match_c & hdr_c.rd;
            phase   <= PH_DATA;
            cnt     <= DATA_TOP;
            shreg   <= '0;
          end else begin
            shreg <= shift_next;
            cnt   <= cnt - CNT_W'(1);
          end
        end else begin
          dat_out <= (hit & rd_flag) ? rd_buf[cnt] : 1'b0;
          if (data_done) begin
            if (hit & ~rd_flag) begin
              wr_stb <= 1'b1;
              wdata  <= shift_next;
            end
            phase <= PH_HDR;
            cnt   <= HDR_TOP;
            shreg <= '0;
          end else begin
            shreg <= shift_next;
            cnt   <= cnt - CNT_W'(1);
          end
        end
      end
    end
  end

  assert_hold_no_edge_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!bclk_rise && !sel_n_s) |=> ($stable(cnt) && $stable(shreg)));

  assert_sel_abort_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sel_n_s |=> (phase == PH_HDR && cnt == HDR_TOP && shreg == '0 && !dat_oe && !hit));

  assert_wr_after_last_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> ($past(phase) == PH_DATA && $past(cnt) == '0));

  assert_strobe_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_stb && rd_stb));

  assert_rd_at_header_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |-> (phase == PH_DATA && cnt == DATA_TOP));

  assert_back_to_header_R6: assert property (@(posedge clk) disable iff (!rst_n)
    data_done |=> (phase == PH_HDR && cnt == HDR_TOP));

  assert_silent_mismatch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb || rd_stb || dat_oe) |-> hit);

  assert_oe_read_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dat_oe |-> rd_flag);
endmodule

// File: rtl/sbt_target.sv
module sbt_target
  import sbt_pkg::*;
#(
  parameter logic [DEV_W-1:0] TARGET_ID   = 3'd1,
  parameter int unsigned      SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel_n,
  input  logic              bus_clk,
  input  logic              bus_dat_in,
  output logic              bus_dat_out,
  output logic              bus_dat_oe,
  output logic              reg_sel,
  output logic              reg_rd,
  output logic              reg_wr,
  output logic [REG_W-1:0]  reg_idx,
  output logic [DATA_W-1:0] reg_wdata,
  input  logic [DATA_W-1:0] reg_rdata
);
  logic sel_n_s, dat_s, bclk_rise;

  sbt_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_n_raw (bus_sel_n),
    .bclk_raw  (bus_clk),
    .dat_raw   (bus_dat_in),
    .sel_n_s   (sel_n_s),
    .dat_s     (dat_s),
    .bclk_rise (bclk_rise)
  );

  sbt_frame #(.TARGET_ID(TARGET_ID)) u_frame (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_n_s   (sel_n_s),
    .dat_s     (dat_s),
    .bclk_rise (bclk_rise),
    .rdata     (reg_rdata),
    .hit       (reg_sel),
    .rd_stb    (reg_rd),
    .wr_stb    (reg_wr),
    .idx       (reg_idx),
    .wdata     (reg_wdata),
    .dat_out   (bus_dat_out),
    .dat_oe    (bus_dat_oe)
  );

  assert_strobe_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> !reg_wr);

  assert_reset_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!bus_dat_oe && !reg_rd && !reg_wr));
endmodule

// File: tb/tb_sbt_target.sv
`timescale 1ns/1ps
module tb_sbt_target;
  localparam int HALF = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_sel_n = 1'b1, bus_clk = 1'b0, bus_dat_in = 1'b0;
  logic bus_dat_out, bus_dat_oe, reg_sel, reg_rd, reg_wr;
  logic [4:0]  reg_idx;
  logic [15:0] reg_wdata, reg_rdata;

  int checks = 0, errors = 0;
  int wr_cnt = 0, rd_cnt = 0;
  logic [4:0]  wr_idx, rd_idx;
  logic [15:0] wr_data;

  always #4 clk = ~clk;

  function automatic logic [15:0] model_rd(input logic [4:0] i);
    return {3'b101, i, 3'b010, ~i};
  endfunction
  assign reg_rdata = model_rd(reg_idx);

  sbt_target dut (
    .clk(clk), .rst_n(rst_n), .bus_sel_n(bus_sel_n), .bus_clk(bus_clk),
    .bus_dat_in(bus_dat_in), .bus_dat_out(bus_dat_out), .bus_dat_oe(bus_dat_oe),
    .reg_sel(reg_sel), .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_idx(reg_idx),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  always @(posedge clk) if (rst_n) begin
    if (reg_wr) begin wr_cnt++; wr_idx = reg_idx; wr_data = reg_wdata; end
    if (reg_rd) begin rd_cnt++; rd_idx = reg_idx; end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_bit(input logic d);
    bus_dat_in = d;
    bus_clk = 1'b0;
    repeat (HALF) @(negedge clk);
    bus_clk = 1'b1;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic run_frame(input logic [8:0] h, input logic [15:0] d,
                           output logic [15:0] got, output int oe_hi);
    got = '0; oe_hi = 0;
    for (int i = 8; i >= 0; i--) bus_bit(h[i]);
    for (int i = 15; i >= 0; i--) begin
      bus_bit(d[i]);
      got[i] = bus_dat_out;
      if (bus_dat_oe) oe_hi++;
    end
  endtask

  // {target[2:0], read, index[4:0], data[15:0]}
  localparam logic [24:0] VEC [8] = '{
    {3'd1, 1'b0, 5'd3,  16'hBEEF},
    {3'd1, 1'b1, 5'd3,  16'h0000},
    {3'd1, 1'b0, 5'd31, 16'h8001},
    {3'd5, 1'b0, 5'd2,  16'h1234},
    {3'd1, 1'b1, 5'd0,  16'h0000},
    {3'd6, 1'b1, 5'd4,  16'h0000},
    {3'd1, 1'b1, 5'd31, 16'hFFFF},
    {3'd1, 1'b0, 5'd0,  16'h0000}
  };

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] got;
    int oe_hi, w0, r0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 oe", bus_dat_oe, 0);
    check("R9 dout", bus_dat_out, 0);
    check("R9 sel", reg_sel, 0);
    check("R9 strobes", wr_cnt + rd_cnt, 0);

    // R1 clocking with select high does nothing
    for (int i = 0; i < 30; i++) bus_bit(1'b1);
    check("R1 no strobe while deselected", wr_cnt + rd_cnt, 0);
    check("R1 oe low while deselected", bus_dat_oe, 0);

    // Table walk, select held low throughout (R6)
    bus_sel_n = 1'b0;
    for (int v = 0; v < 8; v++) begin
      logic [2:0] tgt; logic rd; logic [4:0] ix; logic [15:0] dv; logic m;
      tgt = VEC[v][24:22]; rd = VEC[v][21]; ix = VEC[v][20:16]; dv = VEC[v][15:0];
      m = (tgt == 3'd1);
      w0 = wr_cnt; r0 = rd_cnt;
      run_frame(VEC[v][24:16], dv, got, oe_hi);
      check("R10 reg_sel after frame", reg_sel, m);
      if (!m) begin
        check("R7 no strobes on mismatch", (wr_cnt - w0) + (rd_cnt - r0), 0);
        check("R7 oe never high on mismatch", oe_hi, 0);
      end else if (!rd) begin
        check("R4 one write strobe", wr_cnt - w0, 1);
        check("R3 write index", wr_idx, ix);
        check("R4 write data", wr_data, dv);
        check("R6 no read strobe", rd_cnt - r0, 0);
        check("R8 oe low on write", oe_hi, 0);
      end else begin
        check("R5 one read strobe", rd_cnt - r0, 1);
        check("R3 read index", rd_idx, ix);
        check("R5 read data MSB first", got, model_rd(ix));
        check("R8 oe over data phase", oe_hi, 16);
      end
    end

    // R8: after a read frame the enable drops on the next rising edge
    run_frame({3'd1, 1'b1, 5'd12}, 16'h0, got, oe_hi);
    check("R5 read reg 12", got, model_rd(5'd12));
    check("R8 oe held after last bit", bus_dat_oe, 1);
    bus_bit(1'b0);
    check("R8 oe falls on next edge", bus_dat_oe, 0);
    bus_sel_n = 1'b1;
    repeat (10) @(negedge clk);

    // R2: abort in header, then a clean write
    bus_sel_n = 1'b0;
    w0 = wr_cnt;
    for (int i = 0; i < 5; i++) bus_bit(1'b1);
    bus_sel_n = 1'b1;
    repeat (10) @(negedge clk);
    check("R2 no strobe from partial header", wr_cnt - w0, 0);
    bus_sel_n = 1'b0;
    run_frame({3'd1, 1'b0, 5'd7}, 16'h5A0F, got, oe_hi);
    check("R2 clean frame after abort", {wr_idx, wr_data}, {5'd7, 16'h5A0F});

    // R2: abort during read data phase
    r0 = rd_cnt;
    for (int i = 8; i >= 0; i--) bus_bit(VEC[4][16 + i]);
    for (int i = 0; i < 4; i++) bus_bit(1'b0);
    check("R8 oe high mid read", bus_dat_oe, 1);
    bus_sel_n = 1'b1;
    repeat (10) @(negedge clk);
    check("R2 oe drops on select high", bus_dat_oe, 0);
    check("R10 reg_sel drops on select high", reg_sel, 0);
    bus_sel_n = 1'b0;
    run_frame({3'd1, 1'b1, 5'd21}, 16'h0, got, oe_hi);
    check("R2 read after abort", got, model_rd(5'd21));

    // R4: no write before the 16th bit
    bus_bit(1'b0);
    w0 = wr_cnt;
    bus_sel_n = 1'b1; repeat (10) @(negedge clk); bus_sel_n = 1'b0;
    for (int i = 8; i >= 0; i--) bus_bit(((9'h1 << 6) | 9'd9) >> i);
    for (int i = 15; i >= 1; i--) bus_bit(16'hC3A5 >> i);
    check("R4 no write after 15 bits", wr_cnt - w0, 0);
    bus_bit(1'b1);
    check("R4 write after 16th bit", wr_cnt - w0, 1);
    check("R4 data of late write", {wr_idx, wr_data}, {5'd9, 16'hC3A5});

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule